// File: doc/BRIEF.md
# Power-On Reset Sequencer with Host-Loaded Configuration

This block orders the release of a chip's hard and soft resets after power-on. When the power-on reset input goes high, it reads a strap pin once to choose between two modes. In host mode, an external host must load a 32-bit configuration word through a byte-wide write port before hard reset can be released. In default mode, a built-in configuration word is used and the block does not wait for the host.

Hard reset is released once three things are true: the configuration word is complete, the PLL reports lock, and the DLL (when enabled) is locked. The block then waits a fixed hold interval before releasing hard reset. Soft reset follows a few clocks later. The DLL is represented by an internal counter that starts at PLL lock, so the release cycle can be predicted exactly from the PLL lock cycle. The captured configuration word is presented on an output bus for the rest of the chip.

Top module: `reset_sequencer`

## Requirements
- R1: While por_n is low, hreset_n, sreset_n and cfg_word are all 0. The byte position and the completion flag are cleared, so the next host load starts again at bits 31:24.
- R2: host_strap is captured at the first rising clock edge at which por_n is sampled high. Later changes of host_strap have no effect until the next power-on reset.
- R3: In host mode, four accepted byte writes assemble cfg_word most significant byte first: the first write fills bits 31:24 and the fourth fills bits 7:0. The fourth write marks the word complete.
- R4: In host mode, writes that arrive after the word is complete leave cfg_word unchanged.
- R5: In host mode, hreset_n stays 0 while the word is incomplete. hreset_n rises at edge max(L, W) + 512, where L is the edge at which lock is reached and W is the edge that captures the fourth write.
- R6: In default mode, cfg_word becomes 0x00004C21 at the strap-capture edge, all writes are ignored, and release timing depends on lock only.
- R7: With dll_en low, L is the first edge that samples pll_lock high (E0), so hreset_n rises at edge E0 + 512 when the word is already complete.
- R8: With dll_en high, the internal DLL lock occurs at edge E0 + 3073, so hreset_n rises at edge E0 + 3585 when the word is already complete.
- R9: sreset_n rises exactly 3 clock edges after hreset_n rises.
- R10: Once hreset_n is high, it stays high until por_n is next driven low.
- R11: Byte writes with cfg_addr different from the configuration address (4'h6) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| host_strap | input | 1 | Mode strap; high selects host configuration mode |
| dll_en | input | 1 | High when the DLL is in use; adds the DLL lock delay |
| pll_lock | input | 1 | PLL lock indication |
| cfg_wr | input | 1 | Byte write strobe, one write per cycle high |
| cfg_addr | input | 4 | Write address |
| cfg_wdata | input | 8 | Write data byte |
| hreset_n | output | 1 | Hard reset, active low |
| sreset_n | output | 1 | Soft reset, active low |
| cfg_word | output | 32 | Captured configuration word |

## Verification
A wrong byte position or a lost completion flag shows up on cfg_word as soon as the word is complete, or as a hard reset that never releases. A miscounted hold or DLL counter moves the rising edge of hreset_n away from the expected cycle, and the bench sees this on the exact cycle. A stale strap capture or an uncleared write index left over from an earlier power-on shows up in the next sequence, either as a misplaced byte or as the wrong release timing.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        REL_WAIT,
        REL_HOLD,
        REL_SOFT,
        REL_DONE
    } rel_state_t;

    localparam logic [31:0] RSTSEQ_DEFAULT_WORD = 32'h0000_4C21;

endpackage

// File: rtl/rstseq_cfg_loader.sv
module rstseq_cfg_loader #(
    parameter int          WORD_W       = 32,
    parameter int          BYTE_W       = 8,
    parameter int          ADDR_W       = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 4'h6,
    parameter logic [WORD_W-1:0] DEFAULT_WORD = 32'h0000_4C21
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              strap,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              host_mode,
    output logic              cfg_valid,
    output logic [WORD_W-1:0] cfg_word
);

    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        logic              sampled;
        logic              host;
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
    } ldr_t;

    ldr_t ldr_q, ldr_d;

    always_comb begin
        ldr_d = ldr_q;
        if (!ldr_q.sampled) begin
            ldr_d.sampled = 1'b1;
            ldr_d.host    = strap;
            if (!strap) begin
                ldr_d.valid = 1'b1;
                ldr_d.word  = DEFAULT_WORD;
            end
        end else if (ldr_q.host && !ldr_q.valid && wr && (addr == CFG_ADDR)) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (ldr_q.idx == IDX_W'(NBYTES - 1 - b)) begin
                    ldr_d.word[b*BYTE_W +: BYTE_W] = wdata;
                end
            end
            if (ldr_q.idx == IDX_W'(NBYTES - 1)) begin
                ldr_d.valid = 1'b1;
                ldr_d.idx   = '0;
            end else begin
                ldr_d.idx = ldr_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ldr_q <= '0;
        end else begin
            ldr_q <= ldr_d;
        end
    end

    assign host_mode = ldr_q.host;
    assign cfg_valid = ldr_q.valid;
    assign cfg_word  = ldr_q.word;

    // R4: a completed word is frozen and stays complete
    a_r4_word_frozen: assert property (@(posedge clk) disable iff (!por_n)
        ldr_q.valid |=> (ldr_q.valid && $stable(ldr_q.word)));

    // R2: mode captured once per power-on
    a_r2_mode_stable: assert property (@(posedge clk) disable iff (!por_n)
        ldr_q.sampled |=> (ldr_q.sampled && $stable(ldr_q.host)));

endmodule

// File: rtl/rstseq_dll_model.sv
module rstseq_dll_model #(
    parameter int DLL_DLY = 3073
) (
    input  logic clk,
    input  logic por_n,
    input  logic dll_en,
    input  logic pll_lock,
    output logic locked
);

    localparam int CNT_W = $clog2(DLL_DLY + 1);

    typedef struct packed {
        logic             seen;
        logic [CNT_W-1:0] cnt;
        logic             lock;
    } dll_t;

    dll_t dll_q, dll_d;
    logic run;

    always_comb begin
        dll_d = dll_q;
        run   = dll_q.seen || pll_lock;
        if (run) begin
            dll_d.seen = 1'b1;
            if (dll_q.cnt < CNT_W'(DLL_DLY)) begin
                dll_d.cnt = dll_q.cnt + 1'b1;
            end
        end
        dll_d.lock = dll_q.lock || (dll_en && (dll_q.cnt >= CNT_W'(DLL_DLY)));
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            dll_q <= '0;
        end else begin
            dll_q <= dll_d;
        end
    end

    assign locked = dll_en ? dll_q.lock : dll_q.seen;

    // R8: DLL lock is sticky once reached
    a_r8_dll_sticky: assert property (@(posedge clk) disable iff (!por_n)
        dll_q.lock |=> dll_q.lock);

    // R8: DLL never locks before the PLL has been seen
    a_r8_dll_after_pll: assert property (@(posedge clk) disable iff (!por_n)
        dll_q.lock |-> dll_q.seen);

endmodule

// File: rtl/rstseq_release_timer.sv
module rstseq_release_timer
    import rstseq_pkg::*;
#(
    parameter int HOLD_CLKS = 512,
    parameter int SOFT_CLKS = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic go,
    output logic hreset_n,
    output logic sreset_n
);

    localparam int MAXC  = (HOLD_CLKS > SOFT_CLKS) ? HOLD_CLKS : SOFT_CLKS;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        rel_state_t       st;
        logic [CNT_W-1:0] cnt;
        logic             hrel;
        logic             srel;
    } rel_t;

    rel_t rel_q, rel_d;

    always_comb begin
        rel_d = rel_q;
        unique case (rel_q.st)
            REL_WAIT: begin
                if (go) begin
                    rel_d.st  = REL_HOLD;
                    rel_d.cnt = CNT_W'(1);
                end
            end
            REL_HOLD: begin
                if (rel_q.cnt == CNT_W'(HOLD_CLKS - 1)) begin
                    rel_d.hrel = 1'b1;
                    rel_d.st   = REL_SOFT;
                    rel_d.cnt  = '0;
                end else begin
                    rel_d.cnt = rel_q.cnt + 1'b1;
                end
            end
            REL_SOFT: begin
                if (rel_q.cnt == CNT_W'(SOFT_CLKS - 1)) begin
                    rel_d.srel = 1'b1;
                    rel_d.st   = REL_DONE;
                end else begin
                    rel_d.cnt = rel_q.cnt + 1'b1;
                end
            end
            default: begin
                rel_d.st = REL_DONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rel_q <= '{st: REL_WAIT, cnt: '0, hrel: 1'b0, srel: 1'b0};
        end else begin
            rel_q <= rel_d;
        end
    end

    assign hreset_n = rel_q.hrel;
    assign sreset_n = rel_q.srel;

    // R10: hard reset never re-asserts without power-on reset
    a_r10_hard_stays: assert property (@(posedge clk) disable iff (!por_n)
        hreset_n |=> hreset_n);

    // R9: soft reset follows hard reset after the soft delay
    a_r9_soft_delay: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sreset_n) |-> ($past(hreset_n, SOFT_CLKS) && !$past(hreset_n, SOFT_CLKS + 1)));

    // R9: soft reset never released while hard reset held
    a_r9_soft_order: assert property (@(posedge clk) disable iff (!por_n)
        !hreset_n |-> !sreset_n);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
    parameter int                WORD_W       = 32,
    parameter int                BYTE_W       = 8,
    parameter int                ADDR_W       = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR     = 4'h6,
    parameter logic [WORD_W-1:0] DEFAULT_WORD = rstseq_pkg::RSTSEQ_DEFAULT_WORD,
    parameter int                DLL_DLY      = 3073,
    parameter int                HOLD_CLKS    = 512,
    parameter int                SOFT_CLKS    = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              host_strap,
    input  logic              dll_en,
    input  logic              pll_lock,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic              hreset_n,
    output logic              sreset_n,
    output logic [WORD_W-1:0] cfg_word
);

    logic host_mode;
    logic cfg_valid;
    logic locked;
    logic go;

    rstseq_cfg_loader #(
        .WORD_W       (WORD_W),
        .BYTE_W       (BYTE_W),
        .ADDR_W       (ADDR_W),
        .CFG_ADDR     (CFG_ADDR),
        .DEFAULT_WORD (DEFAULT_WORD)
    ) u_loader (
        .clk       (clk),
        .por_n     (por_n),
        .strap     (host_strap),
        .wr        (cfg_wr),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .host_mode (host_mode),
        .cfg_valid (cfg_valid),
        .cfg_word  (cfg_word)
    );

    rstseq_dll_model #(
        .DLL_DLY (DLL_DLY)
    ) u_dll (
        .clk      (clk),
        .por_n    (por_n),
        .dll_en   (dll_en),
        .pll_lock (pll_lock),
        .locked   (locked)
    );

    assign go = locked && cfg_valid;

    rstseq_release_timer #(
        .HOLD_CLKS (HOLD_CLKS),
        .SOFT_CLKS (SOFT_CLKS)
    ) u_timer (
        .clk      (clk),
        .por_n    (por_n),
        .go       (go),
        .hreset_n (hreset_n),
        .sreset_n (sreset_n)
    );

    // R5: hard reset held while the host word is incomplete
    a_r5_hold_for_host: assert property (@(posedge clk) disable iff (!por_n)
        (host_mode && !cfg_valid) |-> !hreset_n);

    // R5: hard reset never released before lock
    a_r5_hold_for_lock: assert property (@(posedge clk) disable iff (!por_n)
        !locked |-> !hreset_n);

endmodule

// File: tb/sim_reset_sequencer.sv
module sim_reset_sequencer;

    localparam int          CLK_PERIOD = 10;
    localparam int          HOLD       = 512;
    localparam int          SOFT       = 3;
    localparam int          DLLD       = 3073;
    localparam logic [3:0]  CADDR      = 4'h6;
    localparam logic [31:0] DEFW       = 32'h0000_4C21;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        host_strap = 1'b0;
    logic        dll_en = 1'b0;
    logic        pll_lock = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        hreset_n;
    logic        sreset_n;
    logic [31:0] cfg_word;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;

    reset_sequencer u0 (
        .clk        (clk),
        .por_n      (por_n),
        .host_strap (host_strap),
        .dll_en     (dll_en),
        .pll_lock   (pll_lock),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .hreset_n   (hreset_n),
        .sreset_n   (sreset_n),
        .cfg_word   (cfg_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_release(input bit host, input bit dll, input int e0,
                                       input int w4, input int p);
        int l;
        int c;
        l = dll ? (e0 + DLLD) : e0;
        c = host ? w4 : p;
        return ((l > c) ? l : c) + HOLD;
    endfunction

    task automatic apply_por(input bit host, input bit dll);
        @(negedge clk);
        por_n = 1'b0; pll_lock = 1'b0; cfg_wr = 1'b0;
        host_strap = host; dll_en = dll;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!hreset_n && !sreset_n && cfg_word == 32'h0, "R1", "outputs in reset",
              {hreset_n, sreset_n, cfg_word}, 34'h0);
    endtask

    // host load cut short, then power-on reset again (R1 index clear)
    task automatic partial_load();
        apply_por(1'b1, 1'b0);
        por_n = 1'b1;
        @(negedge clk);
        for (int j = 0; j < 2; j++) begin
            cfg_wr = 1'b1; cfg_addr = CADDR; cfg_wdata = 8'hE0 + 8'(j);
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        pll_lock = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic run_case(input bit host, input bit dll, input int pll_off,
                            input int gap, input logic [31:0] word);
        int rel, p, e0, w4, hexp, hr, sr, last_slot;
        bit drop;
        logic [31:0] wexp;
        apply_por(host, dll);
        por_n = 1'b1;
        rel = cyc;
        p = rel + 1;
        e0 = rel + pll_off + 1;
        w4 = rel + 2 + gap * 3 + 1;
        last_slot = rel + 2 + gap * 4;
        hexp = exp_release(host, dll, e0, w4, p);
        wexp = host ? word : DEFW;
        hr = -1; sr = -1; drop = 1'b0;
        for (int k = 0; k < 6000; k++) begin
            int t;
            t = cyc;
            if (hr >= 0 && !hreset_n) drop = 1'b1;
            if (hreset_n && hr < 0) hr = t;
            if (sreset_n && sr < 0) sr = t;
            if (sr >= 0 && t > last_slot + 1) break;
            if (t > rel) host_strap = 1'($urandom);
            pll_lock = (t >= rel + pll_off);
            cfg_wr = 1'b0;
            if (t == rel + 1) begin
                // R11: write to a different address
                cfg_wr = 1'b1; cfg_addr = CADDR ^ 4'h1; cfg_wdata = 8'h5A;
            end
            for (int j = 0; j <= 4; j++) begin
                if (t == rel + 2 + gap * j) begin
                    cfg_wr = 1'b1; cfg_addr = CADDR;
                    cfg_wdata = (j < 4) ? 8'(word >> (24 - 8 * j)) : ~8'(word);
                end
            end
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        check(hr == hexp, dll ? "R8 R5" : "R7 R5", "hreset_n release cycle", hr, hexp);
        check(sr == hr + SOFT, "R9", "sreset_n release cycle", sr, hr + SOFT);
        check(cfg_word == wexp, host ? "R3 R4 R11 R2" : "R6 R2", "cfg_word",
              cfg_word, wexp);
        check(!drop, "R10", "hreset_n stayed released", drop, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (2) @(negedge clk);
        // directed corners
        run_case(1'b1, 1'b0, 0,   1,  32'h1234_5678);  // host completion dominates
        run_case(1'b1, 1'b0, 400, 2,  32'hCAFE_F00D);  // lock dominates (R7)
        partial_load();
        run_case(1'b1, 1'b1, 10,  3,  32'hA1B2_C3D4);  // DLL path (R8), fresh index (R1)
        run_case(1'b0, 1'b0, 0,   1,  32'hFFFF_FFFF);  // default mode (R6)
        run_case(1'b0, 1'b1, 25,  4,  32'h0BAD_0BAD);
        run_case(1'b1, 1'b0, 700, 50, 32'h8000_0001);  // late lock, slow writes
        // constrained random
        for (int i = 0; i < 6; i++) begin
            run_case(1'($urandom), 1'($urandom), int'($urandom_range(0, 600)),
                     int'($urandom_range(1, 40)), $urandom);
        end
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule